// File: doc/BRIEF.md
# Embedded Program and Erase Algorithm Sequencer

This block runs flash write and erase algorithms by itself, so the host only issues one request and waits. A byte program takes an address and a data byte. The block applies a timed program pulse, reads the byte back, compares it with the data and repeats until the byte matches or the pulse budget runs out. A sector erase takes a mask of sectors. A chip erase takes every sector. For each target sector the block first programs and verifies every byte to zero. It then applies timed erase pulses, and after each pulse it checks byte by byte that the sector reads all ones.

The block drives an abstract array port. That port carries an address, write data, a program strobe, an erase strobe with a one-hot sector select, and a combinational read-back value. Pulse lengths are counted in clock cycles and are set by parameters. While a sector erase is running, a suspend request parks the sequencer in a read-capable idle state. A resume request continues the operation from the exact point where it stopped.

Top module: `flash_algo_seq`

## Requirements
- R1: After reset, busy, done, fail, suspended, arr_prog and arr_erase are all 0.
- R2: Every program pulse holds arr_prog high for exactly PROG_LEN cycles, and every erase pulse holds arr_erase high for exactly ERASE_LEN cycles. Address and write data are stable during a program pulse.
- R3: A request with req_op=2'b01 programs req_data into req_addr. busy stays high until a one-cycle done pulse, and fail is 0 when the byte reads back equal to the data.
- R4: If a program read-back does not match, another pulse is applied. After MAX_PULSES pulses without a match, done pulses with fail=1 and the block returns to idle. fail rises only together with done.
- R5: req_op=2'b10 erases each sector whose bit is set in req_mask (bit i selects addresses i*2^(ADDR_W-SECT_W) and up). Sectors whose bit is clear keep their contents.
- R6: req_op=2'b11 erases every sector of the array.
- R7: Before the first erase pulse on a sector, every byte of that sector has been programmed and verified to 0x00.
- R8: Erase pulses repeat until every byte of the sector reads 0xFF. After MAX_PULSES erase pulses without success, done pulses with fail=1.
- R9: A suspend_req during a sector erase leads to suspended=1 and busy=0, with no strobes. A resume_req continues the erase to a correct result.
- R10: suspend_req has no effect during a byte program or a chip erase. suspended stays 0 and the operation completes.
- R11: req_valid is ignored while busy or suspended.
- R12: arr_prog and arr_erase are never high together. During erase, arr_sect_sel is one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 01 program, 10 sector erase, 11 chip erase |
| req_addr | input | ADDR_W | Byte address for program |
| req_data | input | DATA_W | Data for program |
| req_mask | input | 2**SECT_W | Sector mask for sector erase |
| suspend_req | input | 1 | Suspend a running sector erase |
| resume_req | input | 1 | Resume a suspended erase |
| arr_rdata | input | DATA_W | Array read-back at arr_addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Last operation ran out of pulses |
| suspended | output | 1 | Erase parked |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array program data |
| arr_prog | output | 1 | Program pulse strobe |
| arr_erase | output | 1 | Erase pulse strobe |
| arr_sect_sel | output | 2**SECT_W | One-hot sector being erased |

## Verification
On every cycle, the assertions check the following: the two strobes are exclusive, the sector select is one-hot during erase, address and data are stable across a program pulse, busy and suspended never overlap, no strobe is issued while suspended, fail rises only with done, and the pulse counter never goes past its cap. Only the bench scenarios can show the rest. That covers exact pulse widths, the retry counts, pre-programming to zero before erase, which sectors were erased, resume producing a correct result, and requests or suspends being ignored. To do this, the bench watches a behavioural array whose pulses can be made to take no effect.

// File: rtl/fas_pkg.sv
// Shared types for the program/erase sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package fas_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_PPULSE,
        ST_PVFY,
        ST_EPULSE,
        ST_EVFY,
        ST_SUSP
    } state_e;
endpackage

// File: rtl/fas_pulse_timer.sv
// Pulse-width timer: on start it loads a length and runs for that many cycles.
// expired is high in the last cycle of the pulse.
// Assumes: len >= 1; start is not asserted while running.
module fas_pulse_timer #(
    parameter int TMR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMR_W-1:0] len,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;
    logic             run_q;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= len - 1'b1;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/fas_retry_cnt.sv
// Counter of pulses used for the current byte or erase phase.
// exhausted means the budget of MAX_PULSES is used up.
// Assumes: inc is not asserted once exhausted.
module fas_retry_cnt #(
    parameter int MAX_PULSES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CNT_W = $clog2(MAX_PULSES + 1);
    logic [CNT_W-1:0] cnt_q;

    // Clear on a new phase (possibly counting the pulse started in the same cycle).
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= inc ? CNT_W'(1) : '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign exhausted = (cnt_q == CNT_W'(MAX_PULSES));

    // R4
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_PULSES));
endmodule

// File: rtl/flash_algo_seq.sv
// Program/erase algorithm sequencer. It programs single bytes with pulse/verify
// retries. It erases masked sectors or the whole array: pre-program to zero,
// then erase pulses with a byte-by-byte all-ones verify. A sector erase can be
// suspended and resumed.
// Assumes: arr_rdata reflects arr_addr in the same cycle (combinational read).
module flash_algo_seq #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int SECT_W     = 2,
    parameter int PROG_LEN   = 4,
    parameter int ERASE_LEN  = 16,
    parameter int MAX_PULSES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [2**SECT_W-1:0] req_mask,
    input  logic                 suspend_req,
    input  logic                 resume_req,
    input  logic [DATA_W-1:0]    arr_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 fail,
    output logic                 suspended,
    output logic [ADDR_W-1:0]    arr_addr,
    output logic [DATA_W-1:0]    arr_wdata,
    output logic                 arr_prog,
    output logic                 arr_erase,
    output logic [2**SECT_W-1:0] arr_sect_sel
);
    import fas_pkg::*;

    localparam int NSECT = 2 ** SECT_W;
    localparam int OFF_W = ADDR_W - SECT_W;
    localparam int TMR_W = $clog2(((PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN) + 1);

    state_e              state_q, nxt_raw, nxt, ret_q;
    logic [ADDR_W-1:0]   addr_q, addr_d;
    logic [DATA_W-1:0]   wdata_q, wdata_d;
    logic [NSECT-1:0]    mask_q, mask_d;
    logic [SECT_W:0]     sect_q, sect_d;
    logic                pre_q, pre_d, sectop_q, sectop_d;
    logic                susp_pend_q, take_susp;
    logic                cnt_clr, fin, fin_fail, accept;
    logic                tmr_start, tmr_exp, exhausted;
    logic                done_q, fail_q;
    logic [ADDR_W-1:0]   sect_base;
    logic                last_byte;

    assign sect_base = {sect_q[SECT_W-1:0], {OFF_W{1'b0}}};
    assign last_byte = &addr_q[OFF_W-1:0];

    // Next-state and datapath decisions of the algorithm.
    always_comb begin
        nxt_raw  = state_q;
        addr_d   = addr_q;
        wdata_d  = wdata_q;
        mask_d   = mask_q;
        sect_d   = sect_q;
        pre_d    = pre_q;
        sectop_d = sectop_q;
        cnt_clr  = 1'b0;
        fin      = 1'b0;
        fin_fail = 1'b0;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                case (op_e'(req_op))
                    OP_PROG: begin
                        accept = 1'b1; addr_d = req_addr; wdata_d = req_data;
                        pre_d = 1'b0; sectop_d = 1'b0; cnt_clr = 1'b1;
                        nxt_raw = ST_PPULSE;
                    end
                    OP_SECT: begin
                        accept = 1'b1; mask_d = req_mask; sect_d = '0;
                        sectop_d = 1'b1; nxt_raw = ST_SEL;
                    end
                    OP_CHIP: begin
                        accept = 1'b1; mask_d = '1; sect_d = '0;
                        sectop_d = 1'b0; nxt_raw = ST_SEL;
                    end
                    default: ;
                endcase
            end
            ST_SEL: begin
                if (sect_q == (SECT_W+1)'(NSECT)) begin
                    fin = 1'b1; nxt_raw = ST_IDLE;
                end else if (mask_q[sect_q[SECT_W-1:0]]) begin
                    addr_d = sect_base; wdata_d = '0; pre_d = 1'b1;
                    cnt_clr = 1'b1; nxt_raw = ST_PPULSE;
                end else begin
                    sect_d = sect_q + 1'b1;
                end
            end
            ST_PPULSE: if (tmr_exp) nxt_raw = ST_PVFY;
            ST_PVFY: begin
                if (arr_rdata == wdata_q) begin
                    if (!pre_q) begin
                        fin = 1'b1; nxt_raw = ST_IDLE;
                    end else if (last_byte) begin
                        addr_d = sect_base; cnt_clr = 1'b1; nxt_raw = ST_EPULSE;
                    end else begin
                        addr_d = addr_q + 1'b1; cnt_clr = 1'b1; nxt_raw = ST_PPULSE;
                    end
                end else if (exhausted) begin
                    fin = 1'b1; fin_fail = 1'b1; nxt_raw = ST_IDLE;
                end else begin
                    nxt_raw = ST_PPULSE;
                end
            end
            ST_EPULSE: if (tmr_exp) nxt_raw = ST_EVFY;
            ST_EVFY: begin
                if (arr_rdata == {DATA_W{1'b1}}) begin
                    if (last_byte) begin
                        sect_d = sect_q + 1'b1; nxt_raw = ST_SEL;
                    end else begin
                        addr_d = addr_q + 1'b1;
                    end
                end else if (exhausted) begin
                    fin = 1'b1; fin_fail = 1'b1; nxt_raw = ST_IDLE;
                end else begin
                    nxt_raw = ST_EPULSE;
                end
            end
            ST_SUSP: if (resume_req) nxt_raw = ret_q;
            default: nxt_raw = ST_IDLE;
        endcase
    end

    // A pending suspend is taken at the boundary before a new pulse.
    assign take_susp = susp_pend_q && (state_q != ST_SUSP) && (nxt_raw != state_q) &&
                       ((nxt_raw == ST_PPULSE) || (nxt_raw == ST_EPULSE));
    assign nxt       = take_susp ? ST_SUSP : nxt_raw;
    assign tmr_start = ((nxt == ST_PPULSE) || (nxt == ST_EPULSE)) && (nxt != state_q);

    // State, operand and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; ret_q <= ST_IDLE;
            addr_q <= '0; wdata_q <= '0; mask_q <= '0; sect_q <= '0;
            pre_q <= 1'b0; sectop_q <= 1'b0; susp_pend_q <= 1'b0;
            done_q <= 1'b0; fail_q <= 1'b0;
        end else begin
            state_q  <= nxt;
            addr_q   <= addr_d;
            wdata_q  <= wdata_d;
            mask_q   <= mask_d;
            sect_q   <= sect_d;
            pre_q    <= pre_d;
            sectop_q <= sectop_d;
            if (take_susp) ret_q <= nxt_raw;
            if (take_susp || fin)
                susp_pend_q <= 1'b0;
            else if (suspend_req && sectop_q && (state_q != ST_IDLE) && (state_q != ST_SUSP))
                susp_pend_q <= 1'b1;
            done_q <= fin;
            if (accept)   fail_q <= 1'b0;
            else if (fin) fail_q <= fin_fail;
        end
    end

    fas_pulse_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .len     ((nxt == ST_EPULSE) ? TMR_W'(ERASE_LEN) : TMR_W'(PROG_LEN)),
        .expired (tmr_exp)
    );

    fas_retry_cnt #(.MAX_PULSES(MAX_PULSES)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (tmr_start),
        .exhausted (exhausted)
    );

    assign busy         = (state_q != ST_IDLE) && (state_q != ST_SUSP);
    assign suspended    = (state_q == ST_SUSP);
    assign done         = done_q;
    assign fail         = fail_q;
    assign arr_addr     = addr_q;
    assign arr_wdata    = wdata_q;
    assign arr_prog     = (state_q == ST_PPULSE);
    assign arr_erase    = (state_q == ST_EPULSE);
    assign arr_sect_sel = NSECT'(1) << sect_q[SECT_W-1:0];

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog && arr_erase));
    // R12
    sect_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> ($onehot0(arr_sect_sel) && (arr_sect_sel != '0)));
    // R2
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_prog && $past(arr_prog)) |-> ($stable(arr_addr) && $stable(arr_wdata)));
    // R9
    busy_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && suspended));
    // R9
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!arr_prog && !arr_erase));
    // R4
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);
endmodule

// File: tb/flash_algo_seq_bench.sv
// Directed bench with a behavioural array whose pulses can be made ineffective.
module flash_algo_seq_bench;
    localparam int DW = 8, AW = 8, SW = 2, PL = 4, EL = 16, MP = 5;
    localparam int NS = 4, SS = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [NS-1:0] req_mask = '0;
    logic suspend_req = 1'b0, resume_req = 1'b0;
    logic [DW-1:0] arr_rdata;
    logic busy, done, fail, suspended, arr_prog, arr_erase;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic [NS-1:0] arr_sect_sel;

    int total = 0, bad = 0, cycles = 0;
    logic [7:0] mem [256];
    int prog_seen, erase_seen, prog_w, erase_w, pre_bad;
    int prog_gate = 0, erase_gate = 0;
    logic prev_p, prev_e;

    always #2.5 clk = ~clk;

    flash_algo_seq #(.DATA_W(DW), .ADDR_W(AW), .SECT_W(SW), .PROG_LEN(PL),
                     .ERASE_LEN(EL), .MAX_PULSES(MP)) u_flash_algo_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
        .suspend_req(suspend_req), .resume_req(resume_req), .arr_rdata(arr_rdata),
        .busy(busy), .done(done), .fail(fail), .suspended(suspended),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_prog(arr_prog),
        .arr_erase(arr_erase), .arr_sect_sel(arr_sect_sel));

    assign arr_rdata = mem[arr_addr];

    // Array model: a program can only clear bits, an erase sets a sector to ones.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
            prog_seen = 0; erase_seen = 0; prog_w = 0; erase_w = 0; pre_bad = 0;
            prev_p = 1'b0; prev_e = 1'b0;
        end else begin
            if (arr_prog) begin
                if (!prev_p) begin
                    if (prog_seen >= prog_gate) mem[arr_addr] = mem[arr_addr] & arr_wdata;
                    prog_seen++; prog_w = 0;
                end
                prog_w++;
            end
            if (arr_erase) begin
                if (!prev_e) begin
                    for (int s = 0; s < NS; s++) if (arr_sect_sel[s]) begin
                        for (int j = 0; j < SS; j++) if (mem[s*SS+j] != 8'h00) pre_bad++;
                        if (erase_seen >= erase_gate)
                            for (int j = 0; j < SS; j++) mem[s*SS+j] = 8'hFF;
                    end
                    erase_seen++; erase_w = 0;
                end
                erase_w++;
            end
            prev_p = arr_prog; prev_e = arr_erase;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic [3:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
    endtask

    task automatic wait_done(input int limit, output bit seen, output bit saw_susp);
        seen = 0; saw_susp = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (suspended) saw_susp = 1;
            if (done) seen = 1;
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fail && !suspended && !arr_prog && !arr_erase,
            "R1 reset outputs", {busy, done, fail, suspended, arr_prog, arr_erase}, 0);
    endtask

    task automatic t_program(input logic [7:0] a, input logic [7:0] d, input int extra);
        bit seen, ss; int p0;
        prog_gate = prog_seen + extra; p0 = prog_seen;
        issue(2'b01, a, d, 4'h0);
        chk(busy, "R3 busy during program", busy, 1);
        wait_done(200, seen, ss);
        chk(seen && !fail, "R3 program done without fail", {seen, fail}, 2);
        chk(mem[a] == d, "R3 programmed byte", mem[a], d);
        chk(prog_seen - p0 == extra + 1, "R4 program pulse count", prog_seen - p0, extra + 1);
        chk(prog_w == PL, "R2 program pulse width", prog_w, PL);
    endtask

    task automatic t_prog_fail();
        bit seen, ss; int p0;
        prog_gate = prog_seen + 100; p0 = prog_seen;
        issue(2'b01, 8'h33, 8'h00, 4'h0);
        wait_done(300, seen, ss);
        chk(seen && fail, "R4 program exhaustion sets fail", {seen, fail}, 3);
        chk(prog_seen - p0 == MP, "R4 pulses before fail", prog_seen - p0, MP);
        @(negedge clk);
        chk(!busy, "R4 idle after fail", busy, 0);
        prog_gate = 0;
    endtask

    task automatic t_sector_erase();
        bit seen, ss; int p0, e0;
        p0 = prog_seen; e0 = erase_seen; pre_bad = 0;
        issue(2'b10, 8'h00, 8'h00, 4'b0101);
        wait_done(3000, seen, ss);
        chk(seen && !fail, "R5 sector erase done", {seen, fail}, 2);
        chk(mem[8'h05] == 8'hFF && mem[8'h85] == 8'hFF, "R5 selected sectors erased",
            {mem[8'h05], mem[8'h85]}, 16'hFFFF);
        chk(mem[8'h45] == 8'hA5 && mem[8'hC5] == 8'h77, "R5 unselected sectors kept",
            {mem[8'h45], mem[8'hC5]}, 16'hA577);
        chk(prog_seen - p0 == 2 * SS, "R7 pre-program pulses", prog_seen - p0, 2 * SS);
        chk(pre_bad == 0, "R7 sector zero before erase pulse", pre_bad, 0);
        chk(erase_seen - e0 == 2, "R8 one erase pulse per sector", erase_seen - e0, 2);
        chk(erase_w == EL, "R2 erase pulse width", erase_w, EL);
    endtask

    task automatic t_chip_erase();
        bit seen, ss; int p0, nff;
        p0 = prog_seen; nff = 0;
        issue(2'b11, 8'h00, 8'h00, 4'h0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            suspend_req = (i == 20);
        end
        suspend_req = 1'b0;
        wait_done(5000, seen, ss);
        for (int i = 0; i < 256; i++) if (mem[i] != 8'hFF) nff++;
        chk(seen && !fail && nff == 0, "R6 whole array erased", nff, 0);
        chk(prog_seen - p0 == 256, "R6 every byte pre-programmed", prog_seen - p0, 256);
        chk(!ss, "R10 suspend ignored in chip erase", ss, 0);
    endtask

    task automatic t_erase_retry();
        bit seen, ss; int e0;
        e0 = erase_seen; erase_gate = erase_seen + 2;
        issue(2'b10, 8'h00, 8'h00, 4'b0010);
        wait_done(3000, seen, ss);
        chk(seen && !fail && mem[8'h40] == 8'hFF, "R8 erase retry succeeds", {seen, fail}, 2);
        chk(erase_seen - e0 == 3, "R8 erase pulse count", erase_seen - e0, 3);
    endtask

    task automatic t_erase_fail();
        bit seen, ss; int e0;
        e0 = erase_seen; erase_gate = erase_seen + 100;
        issue(2'b10, 8'h00, 8'h00, 4'b1000);
        wait_done(3000, seen, ss);
        chk(seen && fail, "R8 erase exhaustion sets fail", {seen, fail}, 3);
        chk(erase_seen - e0 == MP, "R8 erase pulses before fail", erase_seen - e0, MP);
        erase_gate = 0;
    endtask

    task automatic t_suspend();
        bit seen, ss, got; int p0, e0;
        issue(2'b10, 8'h00, 8'h00, 4'b0001);
        repeat (40) @(negedge clk);
        chk(busy, "R11 busy before ignored request", busy, 1);
        issue(2'b01, 8'h60, 8'h12, 4'h0);
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (suspended) got = 1;
        end
        chk(got && !busy, "R9 suspended and not busy", {got, busy}, 2);
        p0 = prog_seen; e0 = erase_seen;
        issue(2'b01, 8'h90, 8'h00, 4'h0);
        repeat (30) @(negedge clk);
        chk(suspended && prog_seen == p0 && erase_seen == e0, "R9 no pulses while parked",
            prog_seen - p0, 0);
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
        wait_done(3000, seen, ss);
        chk(seen && !fail && mem[8'h00] == 8'hFF && mem[8'h3F] == 8'hFF,
            "R9 resumed erase completes", mem[8'h3F], 8'hFF);
        chk(mem[8'h90] == 8'hFF, "R11 request while suspended ignored", mem[8'h90], 8'hFF);
        chk(mem[8'h60] == 8'hFF, "R11 request while busy ignored", mem[8'h60], 8'hFF);
    endtask

    task automatic t_prog_no_suspend();
        bit seen, ss;
        prog_gate = prog_seen + 3;
        issue(2'b01, 8'hA0, 8'h0F, 4'h0);
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
        wait_done(300, seen, ss);
        chk(seen && !ss && mem[8'hA0] == 8'h0F, "R10 suspend ignored in program",
            mem[8'hA0], 8'h0F);
        prog_gate = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(8'h05, 8'h3C, 0);
        t_program(8'h45, 8'hA5, 2);
        t_program(8'h85, 8'h11, 0);
        t_program(8'hC5, 8'h77, 1);
        t_prog_fail();
        t_sector_erase();
        t_prog_no_suspend();
        t_chip_erase();
        t_erase_retry();
        t_erase_fail();
        t_suspend();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: an overlong run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule